// File: doc/BRIEF.md
# Integer Execute Unit for a Load-Store Instruction Set

This block is the purely combinational integer datapath of a simple load-store processor. Each cycle the decode stage presents an operation code, two register operands, a constant shift count taken from the instruction word, and the raw 16-bit immediate field. The block answers in the same cycle with a full-width result, a flag that requests an overflow trap, and a write enable for the destination register.

For the immediate forms, the unit builds the second operand itself from the raw immediate. The operation class picks the extension rule: zero-fill for the bitwise forms, sign-fill for the arithmetic and compare forms. Only the trapping add and subtract forms can raise the overflow flag. When they do, the wrapped result is still driven, but the write enable drops so that the destination keeps its old value. Shifts act on the first operand. The count comes from the instruction field for the constant forms, and from the low bits of the second operand for the variable forms.

Top module: `ldst_alu`

## Requirements
- R1: The trapping add, trapping subtract and trapping add-immediate operations raise `ovf_trap` exactly when the two's-complement result overflows 32 bits. In that case `result` still carries the wrapped 32-bit value and `wr_en` is 0.
- R2: The wrapping add, subtract and add-immediate forms, the bitwise operations, the shifts, upper-immediate and the compares never raise `ovf_trap`. For every assigned operation code without a trap, `wr_en` is 1.
- R3: The immediate forms of AND, OR and XOR extend `imm_raw` to 32 bits with zeros, so bits 31:16 of the operand are 0.
- R4: The immediate forms of add (trapping and wrapping) and of both compares extend `imm_raw` with copies of bit 15.
- R5: The signed compare gives 1 when `opnd_a` is less than the second operand as two's-complement numbers, and the unsigned compare gives 1 when it is less as natural numbers. Otherwise the result is 0, and bits 31:1 are always 0. For example, 0x8000_0000 against 0x0000_0001 gives 1 signed and 0 unsigned.
- R6: The register forms of AND, OR, XOR and NOR act bitwise on `opnd_a` and `opnd_b`, and NOR gives the complement of their OR.
- R7: Upper-immediate places `imm_raw` in bits 31:16 and zeros in bits 15:0.
- R8: A logical left or right shift fills vacated positions with 0. An arithmetic right shift fills them with bit 31 of `opnd_a`.
- R9: Constant shifts take their count from `shamt_k`. Variable shifts take it from `opnd_b[4:0]` only, and the upper bits of `opnd_b` have no effect.
- R10: For every immediate form, `opnd_b` has no effect on `result`, `ovf_trap` or `wr_en`.
- R11: Operation codes 24 to 31 are unassigned. They give `result` 0, `ovf_trap` 0 and `wr_en` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code, values from the package enumeration `alu_op_e` |
| opnd_a | input | 32 | First register operand; value to be shifted |
| opnd_b | input | 32 | Second register operand; variable shift count in bits 4:0 |
| shamt_k | input | 5 | Constant shift count from the instruction word |
| imm_raw | input | 16 | Unextended immediate field |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en | output | 1 | Destination write permitted |

## Verification
The bench builds the block with the default parameters: a 32-bit datapath, a 16-bit immediate and a 5-bit shift count. At these values the exact overflow boundaries 0x7FFF_FFFF and 0x8000_0000 can be hit directly, and so can the 31-position shift and the sign bit of the immediate. The bench also sweeps every one of the 32 operation codes with random operands, which covers the eight unassigned codes and the 16 inputs of the immediate extender on both sides of bit 15.

// File: rtl/ldst_alu_pkg.sv
`timescale 1ns/1ps
package ldst_alu_pkg;

  localparam int OP_W     = 5;
  localparam int OP_COUNT = 24;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_TRAP  = 5'd0,
    OP_ADD_WRAP  = 5'd1,
    OP_SUB_TRAP  = 5'd2,
    OP_SUB_WRAP  = 5'd3,
    OP_AND       = 5'd4,
    OP_OR        = 5'd5,
    OP_XOR       = 5'd6,
    OP_NOR       = 5'd7,
    OP_LT_S      = 5'd8,
    OP_LT_U      = 5'd9,
    OP_ADDI_TRAP = 5'd10,
    OP_ADDI_WRAP = 5'd11,
    OP_LTI_S     = 5'd12,
    OP_LTI_U     = 5'd13,
    OP_ANDI      = 5'd14,
    OP_ORI       = 5'd15,
    OP_XORI      = 5'd16,
    OP_UPPER_IMM = 5'd17,
    OP_SHL_K     = 5'd18,
    OP_SHR_K     = 5'd19,
    OP_SRA_K     = 5'd20,
    OP_SHL_V     = 5'd21,
    OP_SHR_V     = 5'd22,
    OP_SRA_V     = 5'd23
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT      = 2'd0,
    SH_RIGHT_LOG = 2'd1,
    SH_RIGHT_ARI = 2'd2
  } shift_kind_e;

  function automatic logic op_is_valid(input logic [OP_W-1:0] op);
    return op < OP_W'(OP_COUNT);
  endfunction

  function automatic logic op_is_trap(input logic [OP_W-1:0] op);
    return op == OP_ADD_TRAP || op == OP_SUB_TRAP || op == OP_ADDI_TRAP;
  endfunction

  function automatic logic op_is_logic_imm(input logic [OP_W-1:0] op);
    return op == OP_ANDI || op == OP_ORI || op == OP_XORI;
  endfunction

  function automatic logic op_is_arith_imm(input logic [OP_W-1:0] op);
    return op == OP_ADDI_TRAP || op == OP_ADDI_WRAP ||
           op == OP_LTI_S     || op == OP_LTI_U;
  endfunction

  function automatic logic op_uses_imm(input logic [OP_W-1:0] op);
    return op_is_logic_imm(op) || op_is_arith_imm(op) || op == OP_UPPER_IMM;
  endfunction

  function automatic logic op_is_compare(input logic [OP_W-1:0] op);
    return op == OP_LT_S || op == OP_LT_U || op == OP_LTI_S || op == OP_LTI_U;
  endfunction

  function automatic logic op_subtracts(input logic [OP_W-1:0] op);
    return op == OP_SUB_TRAP || op == OP_SUB_WRAP || op_is_compare(op);
  endfunction

  function automatic logic op_is_var_shift(input logic [OP_W-1:0] op);
    return op == OP_SHL_V || op == OP_SHR_V || op == OP_SRA_V;
  endfunction

  function automatic logic op_is_shift(input logic [OP_W-1:0] op);
    return op == OP_SHL_K || op == OP_SHR_K || op == OP_SRA_K || op_is_var_shift(op);
  endfunction

  function automatic shift_kind_e op_shift_kind(input logic [OP_W-1:0] op);
    if (op == OP_SHL_K || op == OP_SHL_V) return SH_LEFT;
    if (op == OP_SRA_K || op == OP_SRA_V) return SH_RIGHT_ARI;
    return SH_RIGHT_LOG;
  endfunction

  // Two's-complement overflow of a + b_eff, judged from the three sign bits.
  function automatic logic signed_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

endpackage

// File: rtl/ldst_alu_immext.sv
`timescale 1ns/1ps
module ldst_alu_immext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_raw,
  input  logic              zero_fill,
  output logic [DATA_W-1:0] imm_ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic pad_bit;

  assign pad_bit = zero_fill ? 1'b0 : imm_raw[IMM_W-1];
  assign imm_ext = {{PAD_W{pad_bit}}, imm_raw};
endmodule

// File: rtl/ldst_alu_addsub.sv
`timescale 1ns/1ps
module ldst_alu_addsub
  import ldst_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              sub_en,
  output logic [DATA_W-1:0] sum_out,
  output logic              ovf_out,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide_sum;
  logic              carry_out;

  assign b_eff     = sub_en ? ~b_in : b_in;
  assign wide_sum  = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_en};
  assign sum_out   = wide_sum[DATA_W-1:0];
  assign carry_out = wide_sum[DATA_W];
  assign ovf_out   = signed_ovf(a_in[MSB], b_eff[MSB], sum_out[MSB]);

  // Valid when sub_en is set: a - b borrows exactly when a < b unsigned.
  assign lt_unsigned = ~carry_out;
  assign lt_signed   = sum_out[MSB] ^ ovf_out;
endmodule

// File: rtl/ldst_alu_shift.sv
`timescale 1ns/1ps
module ldst_alu_shift
  import ldst_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] value_in,
  input  logic [SH_W-1:0]   amount,
  input  shift_kind_e       kind,
  output logic [DATA_W-1:0] value_out
);
  logic go_left;
  logic fill_bit;

  assign go_left  = (kind == SH_LEFT);
  assign fill_bit = (kind == SH_RIGHT_ARI) & value_in[DATA_W-1];

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] out_q;
    if (s == 0) begin : g_first
      assign in_q = value_in;
    end else begin : g_next
      assign in_q = g_stage[s-1].out_q;
    end
    assign out_q = !amount[s] ? in_q :
                   go_left    ? {in_q[DATA_W-1-STEP:0], {STEP{1'b0}}} :
                                {{STEP{fill_bit}}, in_q[DATA_W-1:STEP]};
  end

  assign value_out = g_stage[SH_W-1].out_q;
endmodule

// File: rtl/ldst_alu.sv
`timescale 1ns/1ps
module ldst_alu
  import ldst_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = 5
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   shamt_k,
  input  logic [IMM_W-1:0]  imm_raw,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap,
  output logic              wr_en
);
  localparam int LOW_W = DATA_W - IMM_W;

  // Named internal events, visible to the bound checker.
  logic              op_valid;
  logic              use_imm;
  logic              zero_fill;
  logic [DATA_W-1:0] imm_ext_w;
  logic [DATA_W-1:0] b_sel;
  logic              do_sub;
  logic [DATA_W-1:0] sum_w;
  logic              ovf_raw;
  logic              lt_s_w;
  logic              lt_u_w;
  logic [SH_W-1:0]   sh_amt;
  shift_kind_e       sh_kind;
  logic [DATA_W-1:0] sh_out;
  logic              trap_fire;

  assign op_valid  = op_is_valid(op_sel);
  assign use_imm   = op_uses_imm(op_sel);
  assign zero_fill = op_is_logic_imm(op_sel);
  assign do_sub    = op_subtracts(op_sel);
  assign sh_kind   = op_shift_kind(op_sel);
  assign sh_amt    = op_is_var_shift(op_sel) ? opnd_b[SH_W-1:0] : shamt_k;

  ldst_alu_immext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_immext (
    .imm_raw   (imm_raw),
    .zero_fill (zero_fill),
    .imm_ext   (imm_ext_w)
  );

  assign b_sel = use_imm ? imm_ext_w : opnd_b;

  ldst_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_in        (opnd_a),
    .b_in        (b_sel),
    .sub_en      (do_sub),
    .sum_out     (sum_w),
    .ovf_out     (ovf_raw),
    .lt_signed   (lt_s_w),
    .lt_unsigned (lt_u_w)
  );

  ldst_alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .value_in  (opnd_a),
    .amount    (sh_amt),
    .kind      (sh_kind),
    .value_out (sh_out)
  );

  always_comb begin
    unique case (op_sel)
      OP_ADD_TRAP, OP_ADD_WRAP, OP_SUB_TRAP, OP_SUB_WRAP,
      OP_ADDI_TRAP, OP_ADDI_WRAP:                result = sum_w;
      OP_LT_S, OP_LTI_S:                         result = {{(DATA_W-1){1'b0}}, lt_s_w};
      OP_LT_U, OP_LTI_U:                         result = {{(DATA_W-1){1'b0}}, lt_u_w};
      OP_AND, OP_ANDI:                           result = opnd_a & b_sel;
      OP_OR,  OP_ORI:                            result = opnd_a | b_sel;
      OP_XOR, OP_XORI:                           result = opnd_a ^ b_sel;
      OP_NOR:                                    result = ~(opnd_a | b_sel);
      OP_UPPER_IMM:                              result = {imm_raw, {LOW_W{1'b0}}};
      OP_SHL_K, OP_SHR_K, OP_SRA_K,
      OP_SHL_V, OP_SHR_V, OP_SRA_V:              result = sh_out;
      default:                                   result = '0;
    endcase
  end

  assign trap_fire = op_is_trap(op_sel) & ovf_raw;
  assign ovf_trap  = trap_fire;
  assign wr_en     = op_valid & ~trap_fire;
endmodule

// File: rtl/ldst_alu_chk.sv
`timescale 1ns/1ps
module ldst_alu_chk
  import ldst_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [OP_W-1:0]   op_sel,
  input logic [IMM_W-1:0]  imm_raw,
  input logic [DATA_W-1:0] imm_ext_w,
  input logic [DATA_W-1:0] result,
  input logic              ovf_trap,
  input logic              wr_en
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (ovf_trap) begin
      AST_TRAP_BLOCKS_WRITE: assert (!wr_en) else $error("write enabled during trap"); // R1
      AST_TRAP_SIGNED_ONLY: assert (op_is_trap(op_sel)) else $error("trap on non-trapping op"); // R2
    end
    if (op_is_logic_imm(op_sel)) begin
      AST_ZERO_EXTEND: assert (imm_ext_w[DATA_W-1:IMM_W] == '0) else $error("logic imm not zero-filled"); // R3
    end
    if (op_is_arith_imm(op_sel)) begin
      AST_SIGN_EXTEND: assert (imm_ext_w[DATA_W-1:IMM_W] == {PAD_W{imm_raw[IMM_W-1]}}) else $error("arith imm not sign-filled"); // R4
    end
    if (op_is_compare(op_sel)) begin
      AST_COMPARE_BOOL: assert (result[DATA_W-1:1] == '0) else $error("compare result not 0/1"); // R5
    end
    if (op_sel == OP_UPPER_IMM) begin
      AST_UPPER_PLACE: assert (result == {imm_raw, {PAD_W{1'b0}}}) else $error("upper-immediate misplaced"); // R7
    end
    if (!op_is_valid(op_sel)) begin
      AST_UNASSIGNED_QUIET: assert (result == '0 && !ovf_trap && !wr_en) else $error("unassigned code not quiet"); // R11
    end
  end
endmodule

bind ldst_alu ldst_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_sel    (op_sel),
  .imm_raw   (imm_raw),
  .imm_ext_w (imm_ext_w),
  .result    (result),
  .ovf_trap  (ovf_trap),
  .wr_en     (wr_en)
);

// File: tb/ldst_alu_test.sv
`timescale 1ns/1ps
module ldst_alu_test;
  import ldst_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel  = '0;
  logic [31:0] opnd_a  = '0;
  logic [31:0] opnd_b  = '0;
  logic [4:0]  shamt_k = '0;
  logic [15:0] imm_raw = '0;
  logic [31:0] result;
  logic        ovf_trap;
  logic        wr_en;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ldst_alu uut (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .shamt_k  (shamt_k),
    .imm_raw  (imm_raw),
    .result   (result),
    .ovf_trap (ovf_trap),
    .wr_en    (wr_en)
  );

  // Behavioural reference written from the requirements.
  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] k, input logic [15:0] imm,
                       output logic [31:0] r, output logic f, output logic w);
    longint sa, sb, s;
    logic [31:0] zx, sx;
    int amt;
    zx  = {16'h0000, imm};
    sx  = {{16{imm[15]}}, imm};
    sa  = longint'($signed(a));
    r   = 32'h0;
    f   = 1'b0;
    w   = (op < 5'd24);
    amt = (op >= 5'd21) ? int'(b % 32) : int'(k);
    case (op)
      OP_ADD_TRAP, OP_ADD_WRAP, OP_SUB_TRAP, OP_SUB_WRAP, OP_ADDI_TRAP, OP_ADDI_WRAP: begin
        sb = (op >= 5'd10) ? longint'($signed(sx)) : longint'($signed(b));
        s  = (op == OP_SUB_TRAP || op == OP_SUB_WRAP) ? sa - sb : sa + sb;
        r  = s[31:0];
        if ((op == OP_ADD_TRAP || op == OP_SUB_TRAP || op == OP_ADDI_TRAP) &&
            (s > 64'sd2147483647 || s < -64'sd2147483648)) begin
          f = 1'b1;
          w = 1'b0;
        end
      end
      OP_LT_S:  r = ($signed(a) < $signed(b))  ? 32'd1 : 32'd0;
      OP_LTI_S: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      OP_LT_U:  r = (a < b)  ? 32'd1 : 32'd0;
      OP_LTI_U: r = (a < sx) ? 32'd1 : 32'd0;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NOR:  r = ~(a | b);
      OP_ANDI: r = a & zx;
      OP_ORI:  r = a | zx;
      OP_XORI: r = a ^ zx;
      OP_UPPER_IMM: r = {imm, 16'h0000};
      OP_SHL_K, OP_SHL_V: r = a << amt;
      OP_SHR_K, OP_SHR_V: r = a >> amt;
      OP_SRA_K, OP_SRA_V: r = $signed(a) >>> amt;
      default: r = 32'h0;
    endcase
  endtask

  function automatic string req_of(input logic [4:0] op);
    if (op >= 5'd24) return "R11";
    if (op == OP_ADD_TRAP || op == OP_SUB_TRAP || op == OP_ADDI_TRAP) return "R1";
    if (op == OP_ANDI || op == OP_ORI || op == OP_XORI) return "R3";
    if (op == OP_ADDI_WRAP || op == OP_LTI_S || op == OP_LTI_U) return "R4";
    if (op == OP_LT_S || op == OP_LT_U) return "R5";
    if (op >= 5'd4 && op <= 5'd7) return "R6";
    if (op == OP_UPPER_IMM) return "R7";
    if (op >= 5'd18) return "R8";
    return "R2";
  endfunction

  task automatic apply(input string req, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] k, input logic [15:0] imm);
    logic [31:0] er;
    logic ef, ew;
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b; shamt_k = k; imm_raw = imm;
    @(negedge clk);
    model(op, a, b, k, imm, er, ef, ew);
    checks++;
    if (result !== er || ovf_trap !== ef || wr_en !== ew) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h k=%0d imm=%h: got result=%h ovf=%b we=%b, expected result=%h ovf=%b we=%b",
               req, op, a, b, k, imm, result, ovf_trap, wr_en, er, ef, ew);
    end
  endtask

  // R9 / R10 helper: two stimuli that must give identical outputs.
  task automatic same_pair(input string req, input logic [4:0] op, input logic [31:0] a,
                           input logic [31:0] b1, input logic [31:0] b2,
                           input logic [4:0] k, input logic [15:0] imm);
    logic [31:0] r1;
    logic f1, w1;
    apply(req, op, a, b1, k, imm);
    r1 = result; f1 = ovf_trap; w1 = wr_en;
    apply(req, op, a, b2, k, imm);
    checks++;
    if (result !== r1 || ovf_trap !== f1 || wr_en !== w1) begin
      failures++;
      $display("FAIL %s op=%0d opnd_b changed outputs: got %h/%b/%b expected %h/%b/%b",
               req, op, result, ovf_trap, wr_en, r1, f1, w1);
    end
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Reset state: code 0 with zero operands gives zero, no trap, write enabled (R2)
    apply("R2", OP_ADD_TRAP, 32'h0, 32'h0, 5'd0, 16'h0);

    // R1: trapping forms at the overflow boundaries
    apply("R1", OP_ADD_TRAP,  32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 16'h0);
    apply("R1", OP_SUB_TRAP,  32'h8000_0000, 32'h0000_0001, 5'd0, 16'h0);
    apply("R1", OP_SUB_TRAP,  32'h0000_0000, 32'h8000_0000, 5'd0, 16'h0);
    apply("R1", OP_ADDI_TRAP, 32'h7FFF_FFFF, 32'h0,         5'd0, 16'h0001);
    apply("R1", OP_ADDI_TRAP, 32'h8000_0000, 32'h0,         5'd0, 16'hFFFF);
    apply("R1", OP_ADD_TRAP,  32'h0000_0005, 32'h0000_0007, 5'd0, 16'h0);
    apply("R1", OP_ADD_TRAP,  32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 16'h0);

    // R2: wrapping forms never trap
    apply("R2", OP_ADD_WRAP,  32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 16'h0);
    apply("R2", OP_SUB_WRAP,  32'h8000_0000, 32'h0000_0001, 5'd0, 16'h0);
    apply("R2", OP_ADDI_WRAP, 32'h7FFF_FFFF, 32'h0,         5'd0, 16'h0001);

    // R3: zero extension for bitwise immediates
    apply("R3", OP_ANDI, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'h8001);
    apply("R3", OP_ORI,  32'h0000_0000, 32'h0, 5'd0, 16'hFFFF);
    apply("R3", OP_XORI, 32'hFFFF_0000, 32'h0, 5'd0, 16'h8000);

    // R4: sign extension for arithmetic and compare immediates
    apply("R4", OP_ADDI_WRAP, 32'h0,          32'h0, 5'd0, 16'hFFFF);
    apply("R4", OP_LTI_U,     32'h0000_0005,  32'h0, 5'd0, 16'hFFFF);
    apply("R4", OP_LTI_S,     32'h0000_0005,  32'h0, 5'd0, 16'hFFFF);
    apply("R4", OP_LTI_S,     32'hFFFF_FFF0,  32'h0, 5'd0, 16'hFFFF);

    // R5: signed versus unsigned compare
    apply("R5", OP_LT_S, 32'h8000_0000, 32'h0000_0001, 5'd0, 16'h0);
    apply("R5", OP_LT_U, 32'h8000_0000, 32'h0000_0001, 5'd0, 16'h0);
    apply("R5", OP_LT_S, 32'h1234_5678, 32'h1234_5678, 5'd0, 16'h0);
    apply("R5", OP_LT_U, 32'h0000_0001, 32'hFFFF_FFFF, 5'd0, 16'h0);

    // R6: bitwise register forms
    apply("R6", OP_NOR, 32'hF0F0_0000, 32'h0F0F_0000, 5'd0, 16'h0);
    apply("R6", OP_AND, 32'hA5A5_A5A5, 32'hFF00_FF00, 5'd0, 16'h0);
    apply("R6", OP_XOR, 32'hA5A5_A5A5, 32'hFFFF_0000, 5'd0, 16'h0);

    // R7: upper immediate
    apply("R7", OP_UPPER_IMM, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 16'hABCD);

    // R8: fill rules
    apply("R8", OP_SRA_K, 32'h8000_0000, 32'h0, 5'd4,  16'h0);
    apply("R8", OP_SHR_K, 32'h8000_0000, 32'h0, 5'd4,  16'h0);
    apply("R8", OP_SHL_K, 32'h0000_0001, 32'h0, 5'd31, 16'h0);
    apply("R8", OP_SRA_K, 32'h7FFF_FFFF, 32'h0, 5'd31, 16'h0);

    // R9: count sources
    apply("R9", OP_SHL_V, 32'h0000_0001, 32'hFFFF_FFE3, 5'd0,  16'h0);
    apply("R9", OP_SHL_K, 32'h0000_0001, 32'h0000_0007, 5'd2,  16'h0);
    same_pair("R9", OP_SRA_V, 32'h8000_00F0, 32'h0000_0005, 32'hABCD_EF05, 5'd9, 16'h0);

    // R10: immediate forms ignore opnd_b
    same_pair("R10", OP_ANDI,      32'h1234_5678, 32'h0, 32'hFFFF_FFFF, 5'd0, 16'h00FF);
    same_pair("R10", OP_ADDI_TRAP, 32'h7FFF_FFF0, 32'h0, 32'h8000_0000, 5'd0, 16'h0010);
    same_pair("R10", OP_LTI_U,     32'h0000_0003, 32'h0, 32'hFFFF_FFFF, 5'd0, 16'h0002);

    // R11: unassigned codes
    for (int c = 24; c < 32; c++)
      apply("R11", 5'(c), 32'hDEAD_BEEF, 32'h7FFF_FFFF, 5'd3, 16'h1234);

    // Random sweep over every code
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      apply(req_of(op), op, $urandom, $urandom, 5'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule